// File: doc/BRIEF.md
# Ping-Pong Octaword Write Buffer

This block sits between a slow 16-bit peripheral bus that performs block-mode DMA writes and a faster system memory bus. Incoming words are gathered into two buffers of eight words each (one octaword). While one buffer is being filled from the peripheral side, the other buffer can be written out to memory. Peripheral writes are therefore pipelined, and memory sees each buffer as a single burst of its largest size.

A buffer is closed and queued for draining in four cases: its last slot is written, the block ends, the next write address does not follow the previous one, or a flush is requested. Each drain is a fixed burst of four longword beats. Per-word valid flags become byte enables, so a partly filled buffer writes only the words it holds. If the buffer that should take the next word is still full or draining, the peripheral write is held off. A flush request, such as one raised ahead of a coherent read, is acknowledged only once both buffers have been emptied.

Top module: `pingpong_wr_buffer`

## Requirements
- R1: After reset both buffers are empty. With wrValid low, wrReady and memValid are low. A flushReq raised after reset is acknowledged in the same cycle (flushAck high).
- R2: An accepted word goes to slot wrAddr[2:0] of the octaword wrAddr[20:3]. A drain issues four beats with memAddr = {octaword, beat} for beats 0, 1, 2, 3 in that order. In each beat, memData[15:0] is the even slot 2*beat and memData[31:16] is the odd slot 2*beat+1.
- R3: A buffer closes for draining as soon as its slot 7 is written, even when wrLast is low. The next sequential word goes into the other buffer with no stall.
- R4: A word accepted with wrLast high closes its buffer, so a partial block drains without any further writes.
- R5: If a buffer is partly filled and a write arrives whose address is not the previous address plus one, that write is not accepted in that cycle. The filling buffer is closed, and the write is accepted into the other buffer in a later cycle.
- R6: memByteEn[1:0] is 2'b11 when the even word of the beat is valid and 2'b00 otherwise. memByteEn[3:2] does the same for the odd word. Beats that hold no valid word are still issued, with memByteEn = 4'b0000.
- R7: While one buffer is draining, even with memReady held low, the other buffer accepts a full octaword of writes.
- R8: wrReady stays low while the buffer due to take the next word is full or draining. While memValid is high and memReady is low, memValid stays high and memAddr, memData and memByteEn hold steady.
- R9: Buffers drain in the order in which they were closed, so memory sees writes in peripheral order.
- R10: While flushReq is high, no write is accepted and a partly filled buffer is closed and drained. flushAck is high only when flushReq is high and both buffers are empty, so every buffered beat has completed before the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrValid | input | 1 | Peripheral write word present |
| wrAddr | input | 21 | Peripheral word address |
| wrData | input | 16 | Peripheral write word |
| wrLast | input | 1 | This word ends the block |
| wrReady | output | 1 | Word accepted this cycle (combinational) |
| flushReq | input | 1 | Request to empty both buffers |
| flushAck | output | 1 | Buffers empty while flush requested |
| memValid | output | 1 | Memory beat present |
| memReady | input | 1 | Memory takes the beat |
| memAddr | output | 20 | Longword address of the beat |
| memData | output | 32 | Two words of the beat |
| memByteEn | output | 4 | Byte enables of the beat |

## Verification
The fill and drain path is exercised with several write patterns. A whole aligned octaword shows the beat addresses and the word-to-lane placement. A block that starts at slot 6 shows the close at slot 7 apart from the close on block end. A two-word block starting at an odd slot shows the split byte enables. An address jump shows the one-cycle refusal and the move into the second buffer. Holding memReady low during two full octawords separates filling while the other buffer drains from the stall that follows, and then shows that three bursts leave in their original order. A flush with a half-filled buffer shows that the acknowledge waits for the last beat.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  localparam int SLOTS  = 8;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int BEATS  = SLOTS / 2;
  localparam int BEAT_W = $clog2(BEATS);

  typedef enum logic [1:0] {
    BUF_EMPTY,
    BUF_FILL,
    BUF_FULL,
    BUF_DRAIN
  } bufState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic              wrEn;
    logic              wrBuf;
    logic [SLOT_W-1:0] wrSlot;
    logic              tagWr;
    logic              clrEn;
    logic              clrBuf;
    logic              rdBuf;
    logic [BEAT_W-1:0] rdBeat;
  } dpCtl_t;
endpackage

// File: rtl/pwb_datapath.sv
module pwb_datapath
  import pwb_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 21
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dpCtl_t                     ctl,
  input  logic [WORD_W-1:0]          wrData,
  input  logic [ADDR_W-SLOT_W-1:0]   wrTag,
  output logic [ADDR_W-SLOT_W+BEAT_W-1:0] memAddr,
  output logic [2*WORD_W-1:0]        memData,
  output logic [2*(WORD_W/8)-1:0]    memByteEn
);
  localparam int TAG_W = ADDR_W - SLOT_W;
  localparam int BPW   = WORD_W / 8;

  logic [1:0][2*WORD_W-1:0] laneData;
  logic [1:0][1:0]          laneVld;
  logic [1:0][TAG_W-1:0]    laneTag;

  for (genvar b = 0; b < 2; b++) begin : g_buf
    logic [WORD_W-1:0] words [SLOTS];
    logic [SLOTS-1:0]  vld;
    logic [TAG_W-1:0]  tag;
    logic              hitWr;
    logic              hitClr;

    assign hitWr  = ctl.wrEn  && (ctl.wrBuf  == 1'(b));
    assign hitClr = ctl.clrEn && (ctl.clrBuf == 1'(b));

    always_ff @(posedge clk) begin
      if (hitWr) words[ctl.wrSlot] <= wrData;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        vld <= '0;
        tag <= '0;
      end else begin
        if (hitClr)     vld <= '0;
        else if (hitWr) vld[ctl.wrSlot] <= 1'b1;
        if (hitWr && ctl.tagWr) tag <= wrTag;
      end
    end

    assign laneData[b] = {words[{ctl.rdBeat, 1'b1}], words[{ctl.rdBeat, 1'b0}]};
    assign laneVld[b]  = {vld[{ctl.rdBeat, 1'b1}], vld[{ctl.rdBeat, 1'b0}]};
    assign laneTag[b]  = tag;
  end

  assign memData   = laneData[ctl.rdBuf];
  assign memAddr   = {laneTag[ctl.rdBuf], ctl.rdBeat};
  assign memByteEn = {{BPW{laneVld[ctl.rdBuf][1]}}, {BPW{laneVld[ctl.rdBuf][0]}}};
endmodule

// File: rtl/pwb_ctrl.sv
module pwb_ctrl
  import pwb_pkg::*;
#(
  parameter int ADDR_W = 21
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              wrLast,
  output logic              wrReady,
  input  logic              flushReq,
  output logic              flushAck,
  input  logic              memReady,
  output logic              memValid,
  output dpCtl_t            ctl
);
  bufState_t         st     [2];
  bufState_t         stNext [2];
  logic              fillSel;
  logic              drainSel;
  logic [BEAT_W-1:0] beat;
  logic [ADDR_W-1:0] lastAddr;

  bufState_t fillSt;
  bufState_t drainSt;
  logic      seqOk;
  logic      accept;
  logic      closeReq;
  logic      endOfBlk;
  logic      beatDone;
  logic      burstEnd;

  always_comb begin
    fillSt   = st[fillSel];
    drainSt  = st[drainSel];
    seqOk    = (wrAddr == lastAddr + ADDR_W'(1));
    accept   = wrValid && !flushReq &&
               ((fillSt == BUF_EMPTY) || ((fillSt == BUF_FILL) && seqOk));
    closeReq = (fillSt == BUF_FILL) && (flushReq || (wrValid && !seqOk));
    endOfBlk = accept && ((wrAddr[SLOT_W-1:0] == SLOT_W'(SLOTS-1)) || wrLast);
    memValid = (drainSt == BUF_DRAIN);
    beatDone = memValid && memReady;
    burstEnd = beatDone && (beat == BEAT_W'(BEATS-1));

    stNext = st;
    if (accept)                 stNext[fillSel]  = endOfBlk ? BUF_FULL : BUF_FILL;
    if (closeReq)               stNext[fillSel]  = BUF_FULL;
    if (drainSt == BUF_FULL)    stNext[drainSel] = BUF_DRAIN;
    if (burstEnd)               stNext[drainSel] = BUF_EMPTY;

    ctl.wrEn   = accept;
    ctl.wrBuf  = fillSel;
    ctl.wrSlot = wrAddr[SLOT_W-1:0];
    ctl.tagWr  = (fillSt == BUF_EMPTY);
    ctl.clrEn  = burstEnd;
    ctl.clrBuf = drainSel;
    ctl.rdBuf  = drainSel;
    ctl.rdBeat = beat;
  end

  assign wrReady  = accept;
  assign flushAck = flushReq && (st[0] == BUF_EMPTY) && (st[1] == BUF_EMPTY);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 2; i++) st[i] <= BUF_EMPTY;
      fillSel  <= 1'b0;
      drainSel <= 1'b0;
      beat     <= '0;
      lastAddr <= '0;
    end else begin
      st <= stNext;
      if (endOfBlk || closeReq) fillSel <= ~fillSel;
      if (burstEnd) begin
        drainSel <= ~drainSel;
        beat     <= '0;
      end else if (beatDone) begin
        beat <= beat + BEAT_W'(1);
      end
      if (accept) lastAddr <= wrAddr;
    end
  end
endmodule

// File: rtl/pingpong_wr_buffer.sv
module pingpong_wr_buffer
  import pwb_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 21
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wrValid,
  input  logic [ADDR_W-1:0]       wrAddr,
  input  logic [WORD_W-1:0]       wrData,
  input  logic                    wrLast,
  output logic                    wrReady,
  input  logic                    flushReq,
  output logic                    flushAck,
  output logic                    memValid,
  input  logic                    memReady,
  output logic [ADDR_W-2:0]       memAddr,
  output logic [2*WORD_W-1:0]     memData,
  output logic [2*(WORD_W/8)-1:0] memByteEn
);
  dpCtl_t ctl;

  pwb_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrValid  (wrValid),
    .wrAddr   (wrAddr),
    .wrLast   (wrLast),
    .wrReady  (wrReady),
    .flushReq (flushReq),
    .flushAck (flushAck),
    .memReady (memReady),
    .memValid (memValid),
    .ctl      (ctl)
  );

  pwb_datapath #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .wrData    (wrData),
    .wrTag     (wrAddr[ADDR_W-1:SLOT_W]),
    .memAddr   (memAddr),
    .memData   (memData),
    .memByteEn (memByteEn)
  );
endmodule

// File: rtl/pingpong_wr_buffer_chk.sv
module pingpong_wr_buffer_chk #(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 21
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    wrValid,
  input logic                    wrReady,
  input logic                    flushReq,
  input logic                    flushAck,
  input logic                    memValid,
  input logic                    memReady,
  input logic [ADDR_W-2:0]       memAddr,
  input logic [2*WORD_W-1:0]     memData,
  input logic [2*(WORD_W/8)-1:0] memByteEn
);
  logic [1:0] beatIdx;
  assign beatIdx = memAddr[1:0];

  // R8: a beat refused by memory is held unchanged
  p_hold_beat_r8: assert property (@(posedge clk) disable iff (!rstN)
    memValid && !memReady |=> memValid && $stable(memAddr) && $stable(memData) && $stable(memByteEn));

  // R8: acceptance only for a presented word
  p_ready_qualified_r8: assert property (@(posedge clk) disable iff (!rstN)
    wrReady |-> wrValid);

  // R10: no write accepted during a flush
  p_flush_gate_r10: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |-> !wrReady);

  // R10: acknowledge only with no beat outstanding
  p_flush_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    flushAck |-> !memValid);

  // R2: every burst begins at beat 0
  p_beat_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memValid) |-> beatIdx == 2'd0);

  // R2: beats inside a burst step upward by one
  p_beat_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    memValid && memReady && beatIdx != 2'd3 |=> memValid && (beatIdx == $past(beatIdx) + 2'd1));
endmodule

bind pingpong_wr_buffer pingpong_wr_buffer_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrValid   (wrValid),
  .wrReady   (wrReady),
  .flushReq  (flushReq),
  .flushAck  (flushAck),
  .memValid  (memValid),
  .memReady  (memReady),
  .memAddr   (memAddr),
  .memData   (memData),
  .memByteEn (memByteEn)
);

// File: tb/test_pingpong_wr_buffer.sv
`timescale 1ns/1ps
module test_pingpong_wr_buffer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrValid = 1'b0;
  logic [20:0] wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        wrLast = 1'b0;
  logic        wrReady;
  logic        flushReq = 1'b0;
  logic        flushAck;
  logic        memValid;
  logic        memReady = 1'b1;
  logic [19:0] memAddr;
  logic [31:0] memData;
  logic [3:0]  memByteEn;

  int nChecks = 0;
  int nFail   = 0;
  int capN    = 0;
  logic [19:0] capAddr [64];
  logic [31:0] capData [64];
  logic [3:0]  capBe   [64];

  always #2.5 clk = ~clk;

  pingpong_wr_buffer i_pingpong_wr_buffer (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData),
    .wrLast(wrLast), .wrReady(wrReady), .flushReq(flushReq), .flushAck(flushAck),
    .memValid(memValid), .memReady(memReady), .memAddr(memAddr), .memData(memData),
    .memByteEn(memByteEn)
  );

  // memory-side monitor: a beat completes when valid and ready meet at an edge
  always @(negedge clk) begin
    if (rstN && memValid && memReady) begin
      if (capN < 64) begin
        capAddr[capN] = memAddr;
        capData[capN] = memData;
        capBe[capN]   = memByteEn;
      end
      capN = capN + 1;
    end
  end

  function automatic logic [15:0] mk(input logic [20:0] a);
    return {4'hC, a[11:0]};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  // drive one word; inputs change just after a rising edge
  task automatic putWord(input logic [20:0] a, input logic last);
    bit ok;
    int n;
    wrValid = 1'b1; wrAddr = a; wrData = mk(a); wrLast = last;
    n = 0;
    do begin
      @(negedge clk); ok = wrReady;
      @(posedge clk); #1;
      n++;
    end while (!ok && n < 2000);
    if (!ok) check("R8 write stuck", 0, 1);
    wrValid = 1'b0; wrLast = 1'b0;
  endtask

  task automatic waitBeats(input int target, input string req);
    for (int i = 0; i < 400 && capN < target; i++) @(posedge clk);
    #1;
    check(req, capN, target);
  endtask

  task automatic expBeat(input int idx, input logic [19:0] a, input logic [3:0] be,
                         input logic [15:0] hi, input logic [15:0] lo, input string req);
    logic [31:0] mask;
    mask = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    check(req, capAddr[idx], a);
    check(req, capBe[idx], be);
    check(req, capData[idx] & mask, {hi, lo} & mask);
  endtask

  task automatic testReset;
    @(negedge clk);
    check("R1 wrReady", wrReady, 0);
    check("R1 memValid", memValid, 0);
    @(posedge clk); #1 flushReq = 1'b1;
    @(negedge clk);
    check("R1 flushAck", flushAck, 1);
    @(posedge clk); #1 flushReq = 1'b0;
  endtask

  task automatic testFullOcta;
    int base;
    base = capN;
    for (int i = 0; i < 8; i++) putWord(21'h80 + 21'(i), 1'b0);
    waitBeats(base + 4, "R2 beat count");
    for (int k = 0; k < 4; k++)
      expBeat(base + k, 20'h40 + 20'(k), 4'hF, mk(21'h80 + 21'(2*k+1)), mk(21'h80 + 21'(2*k)), "R2 full octaword");
  endtask

  task automatic testSlotSevenClose;
    int base;
    base = capN;
    putWord(21'h0C6, 1'b0);
    putWord(21'h0C7, 1'b0);
    waitBeats(base + 4, "R3 close at slot 7");
    expBeat(base + 0, 20'h60, 4'h0, 0, 0, "R3 beat0");
    expBeat(base + 3, 20'h63, 4'hF, mk(21'h0C7), mk(21'h0C6), "R3 beat3");
    putWord(21'h0C8, 1'b1);
    waitBeats(base + 8, "R4 last word drains");
    expBeat(base + 4, 20'h64, 4'h3, 0, mk(21'h0C8), "R4 slot0 beat");
    expBeat(base + 5, 20'h65, 4'h0, 0, 0, "R6 empty beat");
  endtask

  task automatic testPartial;
    int base;
    base = capN;
    putWord(21'h103, 1'b0);
    putWord(21'h104, 1'b1);
    waitBeats(base + 4, "R4 partial block");
    expBeat(base + 0, 20'h80, 4'h0, 0, 0, "R6 beat0 none");
    expBeat(base + 1, 20'h81, 4'hC, mk(21'h103), 0, "R6 odd only");
    expBeat(base + 2, 20'h82, 4'h3, 0, mk(21'h104), "R6 even only");
    expBeat(base + 3, 20'h83, 4'h0, 0, 0, "R6 beat3 none");
  endtask

  task automatic testJump;
    int base;
    base = capN;
    putWord(21'h200, 1'b0);
    putWord(21'h201, 1'b0);
    wrValid = 1'b1; wrAddr = 21'h300; wrData = mk(21'h300); wrLast = 1'b1;
    @(negedge clk);
    check("R5 jump refused first cycle", wrReady, 0);
    @(posedge clk); #1;
    @(negedge clk);
    check("R5 jump accepted next cycle", wrReady, 1);
    @(posedge clk); #1 wrValid = 1'b0; wrLast = 1'b0;
    waitBeats(base + 8, "R5 two bursts");
    expBeat(base + 0, 20'h100, 4'hF, mk(21'h201), mk(21'h200), "R5 first buffer");
    expBeat(base + 1, 20'h101, 4'h0, 0, 0, "R5 first buffer tail");
    expBeat(base + 4, 20'h180, 4'h3, 0, mk(21'h300), "R9 second buffer after first");
  endtask

  task automatic testStall;
    int base;
    base = capN;
    memReady = 1'b0;
    for (int i = 0; i < 16; i++) putWord(21'h400 + 21'(i), 1'b0);
    @(negedge clk);
    check("R7 sixteen words taken while draining stalled", capN, base);
    check("R8 beat presented", memValid, 1);
    check("R8 beat address", memAddr, 20'h200);
    @(posedge clk); #1;
    wrValid = 1'b1; wrAddr = 21'h410; wrData = mk(21'h410); wrLast = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R8 stall while both busy", wrReady, 0);
      check("R8 beat held", memAddr, 20'h200);
    end
    @(posedge clk); #1 memReady = 1'b1;
    wrValid = 1'b0; wrLast = 1'b0;
    putWord(21'h410, 1'b1);
    waitBeats(base + 12, "R9 three bursts");
    expBeat(base + 0,  20'h200, 4'hF, mk(21'h401), mk(21'h400), "R9 burst A");
    expBeat(base + 3,  20'h203, 4'hF, mk(21'h407), mk(21'h406), "R9 burst A end");
    expBeat(base + 4,  20'h204, 4'hF, mk(21'h409), mk(21'h408), "R9 burst B");
    expBeat(base + 7,  20'h207, 4'hF, mk(21'h40F), mk(21'h40E), "R9 burst B end");
    expBeat(base + 8,  20'h208, 4'h3, 0, mk(21'h410), "R9 burst C");
  endtask

  task automatic testFlush;
    int base;
    int n;
    base = capN;
    putWord(21'h500, 1'b0);
    putWord(21'h501, 1'b0);
    flushReq = 1'b1;
    wrValid = 1'b1; wrAddr = 21'h502; wrData = mk(21'h502);
    @(negedge clk);
    check("R10 no ack with data held", flushAck, 0);
    check("R10 write refused in flush", wrReady, 0);
    n = 0;
    while (!flushAck && n < 400) begin
      @(negedge clk);
      n++;
    end
    check("R10 flush acknowledged", flushAck, 1);
    check("R10 burst complete before ack", capN, base + 4);
    expBeat(base + 0, 20'h280, 4'hF, mk(21'h501), mk(21'h500), "R10 flushed data");
    @(posedge clk); #1 flushReq = 1'b0; wrValid = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testFullOcta();
    testSlotSevenClose();
    testPartial();
    testJump();
    testStall();
    testFlush();
    repeat (4) @(posedge clk);
    summary();
  end
endmodule